// File: doc/BRIEF.md
# Pad Pull-Resistor Control Registers

This block is an APB slave that holds the pull-resistor settings for one 16-pin GPIO port. It has two registers. One holds a pull-up enable for each pin and the other holds a pull-down enable for each pin. The stored bits go to the pad ring as per-pin pull-up and pull-down requests. These requests are active only while two separate "apply pull configuration" enables are both high. Each of the two CPUs' control logic provides one of those enables.

Every bus access is stretched by a fixed number of wait states, and reads and writes use different counts. The registers are cleared only by the main system reset. A separate standby-exit reset input leaves them alone, so the pull settings hold the pads steady across a low-power period. When a pin has both of its bits set, the pull-down request wins.

Top module: `pad_pull_ctrl`

## Requirements
- R1: After system reset (rst_ni low), both registers read 0x0000_0000 and all pu_o and pd_o bits are 0.
- R2: A write completes with pready_o low in the first three access-phase cycles (psel_i and penable_i high) and high in the fourth.
- R3: A read completes with pready_o low in the first two access-phase cycles and high in the third, with prdata_o valid in that cycle.
- R4: Word offset 0x028 (paddr_i compared on bits 11:2) selects the pull-up register and offset 0x02C selects the pull-down register. Data bit y (0 to 15) controls pin y, and written values read back.
- R5: Data bits 31:16 of both registers always read as zero and ignore written values.
- R6: On a write, pstrb_i[0] enables update of bits 7:0 and pstrb_i[1] enables update of bits 15:8. Lanes whose strobe is 0 keep their value, and pstrb_i[3:2] have no effect.
- R7: Asserting stby_rst_ni low changes neither register nor any output.
- R8: pu_o[y] is 1 exactly when pull-up bit y is 1, pull-down bit y is 0, and apc_a_i and apc_b_i are both 1.
- R9: pd_o[y] is 1 exactly when pull-down bit y is 1 and apc_a_i and apc_b_i are both 1, whatever the pull-up bit.
- R10: While either apc_a_i or apc_b_i is 0, all pu_o and pd_o bits are 0. The stored values are kept and take effect again once both enables are high.
- R11: An access to any other offset completes with the same wait states as R2/R3, reads as zero, and changes no register.
- R12: pslverr_o is never asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous system reset |
| stby_rst_ni | input | 1 | Active-low standby-exit reset; restarts the wait sequencer only |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB enable (access phase) |
| pwrite_i | input | 1 | APB direction, 1 = write |
| paddr_i | input | 12 | APB byte address |
| pwdata_i | input | 32 | APB write data |
| pstrb_i | input | 4 | APB write byte strobes |
| prdata_o | output | 32 | APB read data |
| pready_o | output | 1 | APB ready, stretched by wait states |
| pslverr_o | output | 1 | APB error, always 0 |
| apc_a_i | input | 1 | First apply-pull enable |
| apc_b_i | input | 1 | Second apply-pull enable |
| pu_o | output | 16 | Per-pin pull-up requests to the pads |
| pd_o | output | 16 | Per-pin pull-down requests to the pads |

## Verification
The bench counts the wait cycles of every access. If a design swapped the read and write wait counts, or was off by one, it would report a wrong count on the first transfer. It sets both bits of some pins at once, so a design that let pull-up win, or asserted both requests together, would show the wrong pad value on those pins. It drops each apply enable on its own and pulses the standby-exit reset. A design that used OR instead of AND for the enables, or that cleared the registers on standby exit, would show the wrong outputs or read back zeros. Partial-strobe writes, writes that set the upper data bits, and accesses to unmapped offsets catch designs that ignore lanes, store reserved bits or alias addresses.

// File: rtl/pad_pull_pkg.sv
package pad_pull_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned LANE_W = 8;
  localparam logic [11:0] PU_OFS = 12'h028;
  localparam logic [11:0] PD_OFS = 12'h02C;
endpackage

// File: rtl/apb_wait_seq.sv
module apb_wait_seq #(
  parameter int unsigned WR_WAIT = 3,
  parameter int unsigned RD_WAIT = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stby_rst_ni,
  input  logic psel_i,
  input  logic penable_i,
  input  logic pwrite_i,
  output logic ready_o
);
  localparam int unsigned MAX_WAIT = (WR_WAIT > RD_WAIT) ? WR_WAIT : RD_WAIT;
  localparam int unsigned CNT_W = (MAX_WAIT < 2) ? 1 : $clog2(MAX_WAIT + 1);

  logic             acc;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] target;

  assign acc     = psel_i & penable_i;
  assign target  = pwrite_i ? CNT_W'(WR_WAIT) : CNT_W'(RD_WAIT);
  assign ready_o = acc & (cnt_q == target);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!stby_rst_ni)      cnt_q <= '0;
    else if (acc && !ready_o)   cnt_q <= cnt_q + 1'b1;
    else                        cnt_q <= '0;
  end

  p_ready_in_access_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (psel_i && penable_i));

  p_wr_stretch_r2: assert property (@(posedge clk_i) disable iff (!rst_ni || !stby_rst_ni)
    (ready_o && pwrite_i) |-> ($past(acc, 3) && !$past(ready_o)));

  p_rd_stretch_r3: assert property (@(posedge clk_i) disable iff (!rst_ni || !stby_rst_ni)
    (ready_o && !pwrite_i) |-> ($past(acc, 2) && !$past(ready_o)));
endmodule

// File: rtl/pull_reg_bank.sv
module pull_reg_bank
  import pad_pull_pkg::*;
#(
  parameter int unsigned PIN_N  = 16,
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [PIN_N-1:0]  wdata_i,
  input  logic [PIN_N/LANE_W-1:0] strb_i,
  output logic [PIN_N-1:0]  pu_q_o,
  output logic [PIN_N-1:0]  pd_q_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned LANES = PIN_N / LANE_W;

  logic [PIN_N-1:0] pu_q, pd_q;
  logic             hit_pu, hit_pd;

  assign hit_pu = (addr_i[ADDR_W-1:2] == PU_OFS[ADDR_W-1:2]);
  assign hit_pd = (addr_i[ADDR_W-1:2] == PD_OFS[ADDR_W-1:2]);

  // Not reset by standby exit: only the system reset reaches these flops.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pu_q <= '0;
      pd_q <= '0;
    end else if (wr_en_i) begin
      for (int l = 0; l < LANES; l++) begin
        if (strb_i[l]) begin
          if (hit_pu) pu_q[l*LANE_W +: LANE_W] <= wdata_i[l*LANE_W +: LANE_W];
          if (hit_pd) pd_q[l*LANE_W +: LANE_W] <= wdata_i[l*LANE_W +: LANE_W];
        end
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      if (hit_pu)      rdata_o[PIN_N-1:0] = pu_q;
      else if (hit_pd) rdata_o[PIN_N-1:0] = pd_q;
    end
  end

  assign pu_q_o = pu_q;
  assign pd_q_o = pd_q;

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(pu_q) && $stable(pd_q)));

  p_miss_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !hit_pu && !hit_pd) |=> ($stable(pu_q) && $stable(pd_q)));
endmodule

// File: rtl/pull_out_gate.sv
module pull_out_gate #(
  parameter int unsigned PIN_N = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             apc_a_i,
  input  logic             apc_b_i,
  input  logic [PIN_N-1:0] pu_q_i,
  input  logic [PIN_N-1:0] pd_q_i,
  output logic [PIN_N-1:0] pu_o,
  output logic [PIN_N-1:0] pd_o
);
  logic en;
  assign en = apc_a_i & apc_b_i;

  for (genvar y = 0; y < PIN_N; y++) begin : g_pin
    assign pd_o[y] = en & pd_q_i[y];
    assign pu_o[y] = en & pu_q_i[y] & ~pd_q_i[y];  // pull-down wins
  end

  p_pd_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pu_o & pd_o) == '0);

  p_gate_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(apc_a_i && apc_b_i) |-> (pu_o == '0 && pd_o == '0));
endmodule

// File: rtl/pad_pull_ctrl.sv
module pad_pull_ctrl
  import pad_pull_pkg::*;
#(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned PIN_N   = 16,
  parameter int unsigned WR_WAIT = 3,
  parameter int unsigned RD_WAIT = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stby_rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [31:0]       pwdata_i,
  input  logic [3:0]        pstrb_i,
  output logic [31:0]       prdata_o,
  output logic              pready_o,
  output logic              pslverr_o,
  input  logic              apc_a_i,
  input  logic              apc_b_i,
  output logic [PIN_N-1:0]  pu_o,
  output logic [PIN_N-1:0]  pd_o
);
  localparam int unsigned LANES = PIN_N / LANE_W;

  logic             ready;
  logic             wr_en, rd_en;
  logic [PIN_N-1:0] pu_q, pd_q;
  logic             unused_bits;

  assign unused_bits = ^{pwdata_i[31:PIN_N], pstrb_i[3:LANES]};

  apb_wait_seq #(.WR_WAIT(WR_WAIT), .RD_WAIT(RD_WAIT)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .stby_rst_ni(stby_rst_ni),
    .psel_i(psel_i), .penable_i(penable_i), .pwrite_i(pwrite_i),
    .ready_o(ready)
  );

  assign wr_en = ready & pwrite_i;
  assign rd_en = ready & ~pwrite_i;

  pull_reg_bank #(.PIN_N(PIN_N), .ADDR_W(ADDR_W)) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(paddr_i),
    .wdata_i(pwdata_i[PIN_N-1:0]), .strb_i(pstrb_i[LANES-1:0]),
    .pu_q_o(pu_q), .pd_q_o(pd_q), .rdata_o(prdata_o)
  );

  pull_out_gate #(.PIN_N(PIN_N)) u_gate (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .apc_a_i(apc_a_i), .apc_b_i(apc_b_i),
    .pu_q_i(pu_q), .pd_q_i(pd_q),
    .pu_o(pu_o), .pd_o(pd_o)
  );

  assign pready_o  = ready;
  assign pslverr_o = 1'b0;

  p_rdata_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pready_o |-> (prdata_o == '0));
endmodule

// File: tb/sim_pad_pull_ctrl.sv
module sim_pad_pull_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_ni = 0, stby_rst_ni = 1;
  logic        psel = 0, penable = 0, pwrite = 0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [3:0]  pstrb = '0;
  logic [31:0] prdata;
  logic        pready, pslverr;
  logic        apc_a = 0, apc_b = 0;
  logic [15:0] pu, pd;

  int checks = 0, errors = 0;
  logic [15:0] m_pu = '0, m_pd = '0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pad_pull_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni), .stby_rst_ni(stby_rst_ni),
    .psel_i(psel), .penable_i(penable), .pwrite_i(pwrite),
    .paddr_i(paddr), .pwdata_i(pwdata), .pstrb_i(pstrb),
    .prdata_o(prdata), .pready_o(pready), .pslverr_o(pslverr),
    .apc_a_i(apc_a), .apc_b_i(apc_b), .pu_o(pu), .pd_o(pd)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Reference model compared on every clock (R8, R9, R10, R12)
  task automatic tick();
    logic en;
    @(negedge clk);
    en = apc_a & apc_b;
    check("R9 pd_o", 32'(pd), 32'(en ? m_pd : 16'h0));
    check("R8 pu_o", 32'(pu), 32'(en ? (m_pu & ~m_pd) : 16'h0));
    check("R12 pslverr", 32'(pslverr), 32'h0);
  endtask

  task automatic xfer(bit wr, logic [11:0] a, logic [31:0] d, logic [3:0] s,
                      string req, output logic [31:0] rd);
    int waits = 0;
    psel = 1; penable = 0; pwrite = wr; paddr = a; pwdata = d; pstrb = s;
    tick();
    penable = 1;
    #1;
    while (!pready && waits < 10) begin
      waits++;
      tick();
      #1;
    end
    check(req, 32'(waits), wr ? 32'd3 : 32'd2);
    rd = prdata;
    if (wr) begin
      for (int l = 0; l < 2; l++) if (s[l]) begin
        if (a[11:2] == 10'h00A) m_pu[l*8 +: 8] = d[l*8 +: 8];
        if (a[11:2] == 10'h00B) m_pd[l*8 +: 8] = d[l*8 +: 8];
      end
    end
    tick();
    psel = 0; penable = 0;
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d, logic [3:0] s, string req);
    logic [31:0] r;
    xfer(1, a, d, s, req, r);
  endtask

  task automatic rd_chk(logic [11:0] a, string req);
    logic [31:0] r, e;
    e = (a[11:2] == 10'h00A) ? {16'h0, m_pu} : (a[11:2] == 10'h00B) ? {16'h0, m_pd} : 32'h0;
    xfer(0, a, 32'h0, 4'h0, "R3 read waits", r);
    check(req, r, e);
  endtask

  initial begin
    repeat (3) tick();
    rst_ni = 1;
    tick();
    // R1 reset state
    check("R1 pu_o", 32'(pu), 32'h0);
    check("R1 pd_o", 32'(pd), 32'h0);
    rd_chk(12'h028, "R1 pu reset");
    rd_chk(12'h02C, "R1 pd reset");
    apc_a = 1; apc_b = 1; tick();
    // R4 basic map
    wr(12'h028, 32'h0000_00F0, 4'hF, "R2 write waits");
    wr(12'h02C, 32'h0000_0F00, 4'hF, "R2 write waits");
    rd_chk(12'h028, "R4 pu readback");
    rd_chk(12'h02C, "R4 pd readback");
    // R8 overlap: pull-down wins
    wr(12'h028, 32'h0000_FFFF, 4'hF, "R2 write waits");
    wr(12'h02C, 32'h0000_00FF, 4'hF, "R2 write waits");
    check("R8 overlap", 32'(pu), 32'h0000_FF00);
    check("R9 independent", 32'(pd), 32'h0000_00FF);
    // R5 reserved bits
    wr(12'h028, 32'hABCD_1234, 4'hF, "R2 write waits");
    rd_chk(12'h028, "R5 reserved zero");
    // R6 strobes
    wr(12'h02C, 32'hFFFF_5A5A, 4'b0010, "R2 write waits");
    rd_chk(12'h02C, "R6 upper lane only");
    wr(12'h02C, 32'h0000_FFFF, 4'b1100, "R2 write waits");
    rd_chk(12'h02C, "R6 high strobes no effect");
    wr(12'h028, 32'h0000_00C3, 4'b0001, "R2 write waits");
    rd_chk(12'h028, "R6 lower lane only");
    // R10 enables
    apc_a = 0; tick(); tick();
    check("R10 apc_a low pu", 32'(pu), 32'h0);
    apc_a = 1; apc_b = 0; tick();
    check("R10 apc_b low pd", 32'(pd), 32'h0);
    rd_chk(12'h028, "R10 kept pu");
    apc_b = 1; tick();
    check("R10 restored pd", 32'(pd), 32'(m_pd));
    // R7 standby-exit reset
    stby_rst_ni = 0; tick(); tick(); stby_rst_ni = 1; tick();
    rd_chk(12'h028, "R7 pu survives");
    rd_chk(12'h02C, "R7 pd survives");
    check("R7 pd_o kept", 32'(pd), 32'(m_pd & 16'hFFFF));
    // R11 unmapped offsets
    wr(12'h030, 32'hFFFF_FFFF, 4'hF, "R11 write waits");
    wr(12'h000, 32'hFFFF_FFFF, 4'hF, "R11 write waits");
    rd_chk(12'h030, "R11 unmapped read");
    rd_chk(12'h024, "R11 unmapped read");
    rd_chk(12'h028, "R11 pu untouched");
    rd_chk(12'h02C, "R11 pd untouched");
    repeat (2) tick();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule